// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers event flags from a round-robin monitoring sequencer into two status registers, each `W` bits wide. The sequencer raises per-bit event strobes while a pass runs. These strobes collect in a hidden pending stage. At the sequencer's end-of-loop strobe the collected bits are merged into the visible status registers. The host sees the status only once a full pass has completed.

Two active-low hardware interrupt lines are produced from the status bits. The first is a maskable NMI/IRQ line with a selectable signalling mode. The second is a maskable SMI line. Each line has its own pair of mask registers, with one mask bit per event.

A host register port gives access to the status, mask and configuration registers. Reading a status register returns its contents and then clears that register, which drops the lines it was driving. The lines stay deasserted until the next completed pass sets status bits again. A configuration clear bit forces both lines inactive and stops the monitoring sequencer for as long as the bit is set.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset, both status registers, all four mask registers and the configuration register are zero, `nmi_n` and `smi_n` are high, and `seq_run` is high.
- R2: Event strobes are held in a pending stage and are not visible in the status registers. On a cycle with `loop_done` high, the pending bits plus that cycle's strobes are ORed into the status (group A at address 0, group B at address 1), and the pending stage empties.
- R3: Reading address 0 or 1 with `host_rd` presents the current status on `host_rdata` in the same cycle. From the next cycle that register reads zero, and the other status register is unchanged.
- R4: When a status read and a `loop_done` merge happen in the same cycle, the register afterwards holds exactly the merged bits.
- R5: `smi_n` is low exactly when configuration bit 0 (SMI enable) is 1, configuration bit 3 is 0, and some status bit has its SMI mask bit (addresses 4/5, 1 = masked) at 0.
- R6: With configuration bit 2 at 0 (level mode), `nmi_n` is low exactly when configuration bit 1 (NMI enable) is 1, bit 3 is 0, and some status bit has its NMI mask bit (addresses 2/3, 1 = masked) at 0.
- R7: With configuration bit 2 at 1 (pulse mode), `nmi_n` goes low for one cycle after a merge that newly sets an unmasked status bit, when enabled and bit 3 is 0. A merge of bits that are already set gives no pulse.
- R8: While configuration bit 3 (clear) is 1, both lines are high, `seq_run` is low, and event strobes and `loop_done` are ignored. Pending bits from before are kept and are merged by the first `loop_done` after bit 3 returns to 0.
- R9: Writes to addresses 2 to 6 update the masks and the 4-bit configuration (address 6, bits 3:0, upper bits read 0). Writes to addresses 0, 1 and 7 have no effect, and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_a | input | W | Event strobes, group A |
| ev_b | input | W | Event strobes, group B |
| loop_done | input | 1 | End-of-pass strobe from the sequencer |
| seq_run | output | 1 | High while the sequencer may run |
| host_rd | input | 1 | Register read strobe (clears status on addresses 0/1) |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | W | Write data |
| host_rdata | output | W | Contents of the addressed register |
| nmi_n | output | 1 | Active-low NMI/IRQ line |
| smi_n | output | 1 | Active-low SMI line |

## Verification
The embedded assertions check on every cycle that the clear bit keeps both lines high and freezes the status against merges, and that status only changes through a merge or a read. They also check that a read with no merge empties the register, and that a pulse-mode low is always preceded by a merge. What only the bench scenarios can show is the exact contents returned by reads and the mask and mode interplay on the lines under random traffic. The same applies to the same-cycle read-and-merge case and to pending bits that survive a halt.

// File: rtl/irq_status_ctl.sv
module irq_status_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_a,
  input  logic [W-1:0] ev_b,
  input  logic         loop_done,
  output logic         seq_run,
  input  logic         host_rd,
  input  logic         host_wr,
  input  logic [2:0]   host_addr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic         nmi_n,
  output logic         smi_n
);
  logic [W-1:0] pend_a, pend_b, st_a, st_b;
  logic [W-1:0] nmsk_a, nmsk_b, smsk_a, smsk_b;
  logic [3:0]   cfg;
  logic         pulse_q;

  wire hold    = cfg[3];
  wire merge   = loop_done & ~hold;
  wire rd_a    = host_rd & (host_addr == 3'd0);
  wire rd_b    = host_rd & (host_addr == 3'd1);
  wire [W-1:0] col_a = pend_a | ev_a;
  wire [W-1:0] col_b = pend_b | ev_b;
  wire [W-1:0] fresh = (col_a & ~st_a & ~nmsk_a) | (col_b & ~st_b & ~nmsk_b);

  wire any_nmi = |((st_a & ~nmsk_a) | (st_b & ~nmsk_b));
  wire any_smi = |((st_a & ~smsk_a) | (st_b & ~smsk_b));

  assign seq_run = ~hold;
  assign smi_n   = ~(cfg[0] & ~hold & any_smi);
  assign nmi_n   = ~(cfg[1] & ~hold & (cfg[2] ? pulse_q : any_nmi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a <= '0; pend_b <= '0; st_a <= '0; st_b <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (!hold) begin
        pend_a <= merge ? '0 : col_a;
        pend_b <= merge ? '0 : col_b;
      end
      st_a    <= (rd_a ? '0 : st_a) | (merge ? col_a : '0);
      st_b    <= (rd_b ? '0 : st_b) | (merge ? col_b : '0);
      pulse_q <= merge & (|fresh);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmsk_a <= '0; nmsk_b <= '0; smsk_a <= '0; smsk_b <= '0; cfg <= '0;
    end else if (host_wr) begin
      case (host_addr)
        3'd2: nmsk_a <= host_wdata;
        3'd3: nmsk_b <= host_wdata;
        3'd4: smsk_a <= host_wdata;
        3'd5: smsk_b <= host_wdata;
        3'd6: cfg    <= host_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (host_addr)
      3'd0: host_rdata = st_a;
      3'd1: host_rdata = st_b;
      3'd2: host_rdata = nmsk_a;
      3'd3: host_rdata = nmsk_b;
      3'd4: host_rdata = smsk_a;
      3'd5: host_rdata = smsk_b;
      3'd6: host_rdata = {{(W-4){1'b0}}, cfg};
      default: host_rdata = '0;
    endcase
  end

  assert_clr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (nmi_n && smi_n));
  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !rd_a) |=> $stable(st_a));
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && !loop_done) |=> (st_a == '0));
  assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_done && !rd_b) |=> $stable(st_b));
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2] && !nmi_n && $past(rst_n)) |-> $past(loop_done));
endmodule

// File: tb/irq_status_ctl_bench.sv
`timescale 1ns/1ps
module irq_status_ctl_bench;
  localparam int W = 8;
  localparam real CLK = 4.0;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] ev_a = 0, ev_b = 0, host_wdata = 0;
  logic loop_done = 0, host_rd = 0, host_wr = 0;
  logic [2:0] host_addr = 0;
  wire [W-1:0] host_rdata;
  wire seq_run, nmi_n, smi_n;

  irq_status_ctl #(.W(W)) u_irq_status_ctl (
    .clk(clk), .rst_n(rst_n), .ev_a(ev_a), .ev_b(ev_b), .loop_done(loop_done),
    .seq_run(seq_run), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .nmi_n(nmi_n), .smi_n(smi_n));

  always #(CLK/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [W-1:0] m_pa, m_pb, m_sa, m_sb, m_na, m_nb, m_ma, m_mb;
  logic [3:0] m_cfg;
  logic m_pulse;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_sa;  3'd1: return m_sb;
      3'd2: return m_na;  3'd3: return m_nb;
      3'd4: return m_ma;  3'd5: return m_mb;
      3'd6: return {{(W-4){1'b0}}, m_cfg};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_smi();
    return !(m_cfg[0] && !m_cfg[3] && |((m_sa & ~m_ma) | (m_sb & ~m_mb)));
  endfunction

  function automatic logic exp_nmi();
    logic lvl;
    lvl = |((m_sa & ~m_na) | (m_sb & ~m_nb));
    return !(m_cfg[1] && !m_cfg[3] && (m_cfg[2] ? m_pulse : lvl));
  endfunction

  task automatic m_update(logic [W-1:0] ea, eb, logic dn, rd, wr, logic [2:0] ad, logic [W-1:0] wd);
    logic hold, mg;
    logic [W-1:0] ca, cb;
    hold = m_cfg[3];
    mg = dn && !hold;
    ca = m_pa | ea; cb = m_pb | eb;
    m_pulse = mg && |((ca & ~m_sa & ~m_na) | (cb & ~m_sb & ~m_nb));
    m_sa = ((rd && ad == 0) ? '0 : m_sa) | (mg ? ca : '0);
    m_sb = ((rd && ad == 1) ? '0 : m_sb) | (mg ? cb : '0);
    if (!hold) begin
      m_pa = mg ? '0 : ca;
      m_pb = mg ? '0 : cb;
    end
    if (wr) case (ad)
      3'd2: m_na = wd; 3'd3: m_nb = wd; 3'd4: m_ma = wd; 3'd5: m_mb = wd;
      3'd6: m_cfg = wd[3:0];
      default: ;
    endcase
  endtask

  task automatic lines();
    chk("R5 smi_n", smi_n, exp_smi());
    chk(m_cfg[2] ? "R7 nmi_n pulse" : "R6 nmi_n level", nmi_n, exp_nmi());
    chk("R8 seq_run", seq_run, !m_cfg[3]);
  endtask

  task automatic step(logic [W-1:0] ea, eb, logic dn, rd, wr, logic [2:0] ad,
                      logic [W-1:0] wd, string tag = "");
    ev_a = ea; ev_b = eb; loop_done = dn; host_rd = rd; host_wr = wr;
    host_addr = ad; host_wdata = wd;
    #1;
    if (rd) chk(tag != "" ? tag : (ad <= 1 ? "R3 status read" : "R9 reg read"),
                host_rdata, m_read(ad));
    @(posedge clk);
    m_update(ea, eb, dn, rd, wr, ad, wd);
    @(negedge clk);
    lines();
  endtask

  task automatic rd(logic [2:0] a, string tag = ""); step(0, 0, 0, 1, 0, a, 0, tag); endtask
  task automatic wr(logic [2:0] a, logic [W-1:0] d); step(0, 0, 0, 0, 1, a, d); endtask

  initial begin
    #(CLK * 200000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    m_pa = 0; m_pb = 0; m_sa = 0; m_sb = 0; m_na = 0; m_nb = 0; m_ma = 0; m_mb = 0;
    m_cfg = 0; m_pulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 nmi_n", nmi_n, 1); chk("R1 smi_n", smi_n, 1); chk("R1 seq_run", seq_run, 1);
    for (int a = 0; a < 8; a++) begin
      host_addr = a[2:0]; #1; chk("R1 reg zero", host_rdata, 0);
    end

    // R2: events invisible until loop_done
    wr(6, 8'h03);
    step(8'h05, 8'h00, 0, 0, 0, 0, 0);
    chk("R2 no line before merge", smi_n, 1);
    rd(0, "R2 pending hidden");
    step(8'h00, 8'h80, 1, 0, 0, 0, 0);
    chk("R2 smi after merge", smi_n, 0);
    rd(1, "R2 merged B");
    rd(1, "R3 cleared B");
    rd(0, "R2 merged A");
    chk("R3 line drops", smi_n, 1);

    // R4: read and merge in same cycle
    step(8'h11, 0, 1, 0, 0, 0, 0);
    step(8'h22, 0, 0, 0, 0, 0, 0);
    step(8'h40, 0, 1, 1, 0, 0, 0, "R4 old value");
    rd(0, "R4 merged only");

    // R7: pulse mode, repeat merge of a set bit gives no pulse
    rd(0); wr(6, 8'h06);
    step(8'h08, 0, 1, 0, 0, 0, 0);
    chk("R7 pulse low", nmi_n, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R7 pulse one cycle", nmi_n, 1);
    step(8'h08, 0, 1, 0, 0, 0, 0);
    chk("R7 no repeat pulse", nmi_n, 1);

    // R8: halt ignores events, keeps earlier pending
    wr(6, 8'h03); rd(0);
    step(8'h01, 0, 0, 0, 0, 0, 0);
    wr(6, 8'h0B);
    chk("R8 halted", seq_run, 0);
    step(8'h02, 8'h04, 1, 0, 0, 0, 0);
    rd(0, "R8 no merge in halt");
    wr(6, 8'h03);
    step(0, 0, 1, 0, 0, 0, 0);
    rd(0, "R8 old pending merged");

    // R9: write to status address ignored
    step(8'h10, 0, 1, 0, 0, 0, 0);
    wr(0, 8'hFF); wr(7, 8'hFF);
    rd(0, "R9 status write ignored");
    rd(7, "R9 addr7 zero");

    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] ea, eb, d;
      logic dn, r, w;
      logic [2:0] a;
      int k;
      ea = ($urandom % 4 == 0) ? W'($urandom) : '0;
      eb = ($urandom % 4 == 0) ? W'($urandom) : '0;
      dn = ($urandom % 5 == 0);
      k = $urandom % 10;
      r = (k < 3); w = (k == 3);
      a = 3'($urandom);
      d = W'($urandom);
      if (w && a == 6 && ($urandom % 4 != 0)) d[3] = 1'b0;
      step(ea, eb, dn, r, w, a, d);
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule